// File: doc/BRIEF.md
# Cascadable Interrupt Vector Controller

This block handles the setup and vector-delivery path of one legacy PC-style interrupt controller. The same block serves as the master or the slave of a cascaded pair. Software writes bytes to two ports, an even port and an odd port. A start byte on the even port begins a fixed sequence of four initialization words. The second word supplies the five-bit vector base, and the controller only becomes active once the fourth word has arrived. Cascade operation and the fourth word are always assumed, and the trigger-mode and interval options of the first word have no effect.

There are eight request lines. A separate eight-bit select input makes each line either edge-triggered or level-triggered. Priority is fixed: line 0 is the highest. A request is offered to the processor only if its line outranks every line currently in service. The processor answers with two acknowledge pulses. The first pulse picks the winning line and marks it in service. During the second pulse the block drives an eight-bit vector, made of the stored base joined with the three-bit binary number of the line. A nonspecific end-of-interrupt byte on the even port releases the highest-priority line in service. On a slave, lines 0 to 7 stand for system requests 8 to 15 and use the same codes.

Top module: `pic_vector_gen`

## Requirements
- R1: A write to the even port with data bit 4 set starts initialization and drops `armed`. After it, exactly three writes to the odd port (vector base, cascade identity, fourth word) are needed, and `armed` rises only after the third of them. Bits 3, 1 and 0 of the start byte are ignored. While not armed, `int_req` stays low and acknowledge pulses are ignored.
- R2: The vector base is bits 7:3 of the first odd-port write after a start byte. The low three bits of that byte never affect any vector.
- R3: The driven vector equals base in bits 7:3 and the binary number (0 to 7) of the serviced line in bits 2:0.
- R4: Priority is fixed, with line 0 highest. A pending line is eligible only if its number is lower than that of every in-service line.
- R5: An edge-selected line (`lvl_sel` bit 0) latches a request on a 0 to 1 change of its input, seen one clock later. The latch clears when that line is picked by an acknowledge. A level-selected line (`lvl_sel` bit 1) is pending exactly while its input is high.
- R6: `int_req` is high exactly when the block is armed and some eligible request is pending.
- R7: On the first acknowledge rise, the lowest-numbered eligible line is latched and its in-service bit is set. If no line is eligible, code 7 is latched and no in-service bit changes.
- R8: `vec_oe` rises in the cycle after the second acknowledge rise and falls in the cycle after `ack` returns low. `vec_out` reads zero whenever `vec_oe` is low.
- R9: An even-port write with bit 4 clear and bit 5 set, made while armed, clears the lowest-numbered in-service bit.
- R10: A start byte arriving mid-sequence or while armed restarts the word sequence and clears all in-service bits and latched edge requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| wr_port | input | 1 | 0 selects the even port, 1 the odd port |
| wr_data | input | 8 | Write data byte |
| irq_in | input | 8 | Request lines, line 0 highest priority |
| lvl_sel | input | 8 | Per-line trigger select: 1 level, 0 edge |
| ack | input | 1 | Interrupt acknowledge, active high, two pulses per cycle |
| int_req | output | 1 | Interrupt request to the processor or upstream master |
| vec_oe | output | 1 | Vector bus enable, high only during the second acknowledge pulse |
| vec_out | output | 8 | Vector byte, zero while disabled |
| armed | output | 1 | Initialization sequence complete |

## Verification
The bench first uses one edge line alone, then an edge line and a level line asserted together, which shows fixed priority over trigger type. A lower-numbered line is then raised while a higher-numbered line is in service. This separates nested priority from plain pending order, and consecutive end-of-interrupt writes show which in-service bit is released. It also sends acknowledges with nothing pending and acknowledges before arming. It re-initializes with nonzero low bits in the base byte, with an edge request latched beforehand and a restart in the middle of the sequence. This tells a correct base capture and latch clear apart from stale state.

// File: rtl/pic_vec_pkg.sv
`timescale 1ns/1ps
package pic_vec_pkg;

    // Position of the start flag in an even-port byte
    localparam int unsigned CMD_START_BIT = 4;
    // Position of the end-of-interrupt flag in an even-port byte
    localparam int unsigned CMD_EOI_BIT   = 5;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WANT_BASE,
        SEQ_WANT_CASC,
        SEQ_WANT_LAST,
        SEQ_READY
    } seq_state_e;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_WAIT2,
        ACK_DRIVE
    } ack_phase_e;

endpackage

// File: rtl/pic_init_seq.sv
`timescale 1ns/1ps
module pic_init_seq
    import pic_vec_pkg::*;
#(
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned CODE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_port,
    input  logic [VEC_W-1:0]        wr_data,
    output logic                    init_start,
    output logic                    eoi_cmd,
    output logic                    armed,
    output logic [VEC_W-CODE_W-1:0] base
);

    localparam int unsigned BASE_W = VEC_W - CODE_W;

    typedef struct packed {
        seq_state_e        st;
        logic [BASE_W-1:0] base;
    } seq_t;

    seq_t q, d;

    // Bits of the written byte that no register keeps
    logic seq_unused_bits;
    assign seq_unused_bits = ^wr_data[CODE_W-1:0];

    always_comb begin
        d          = q;
        init_start = wr_en && !wr_port && wr_data[CMD_START_BIT];
        eoi_cmd    = wr_en && !wr_port && !wr_data[CMD_START_BIT]
                     && wr_data[CMD_EOI_BIT] && (q.st == SEQ_READY);
        if (init_start) begin
            d.st = SEQ_WANT_BASE;
        end else if (wr_en && wr_port) begin
            unique case (q.st)
                SEQ_WANT_BASE: begin
                    d.base = wr_data[VEC_W-1:CODE_W];
                    d.st   = SEQ_WANT_CASC;
                end
                SEQ_WANT_CASC: d.st = SEQ_WANT_LAST;
                SEQ_WANT_LAST: d.st = SEQ_READY;
                default:       d.st = q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= SEQ_IDLE;
            q.base <= '0;
        end else begin
            q <= d;
        end
    end

    assign armed = (q.st == SEQ_READY);
    assign base  = q.base;

endmodule

// File: rtl/pic_req_latch.sv
`timescale 1ns/1ps
module pic_req_latch #(
    parameter int unsigned N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] lvl_sel,
    input  logic               clr_all,
    input  logic [N_LINES-1:0] clr_one,
    output logic [N_LINES-1:0] pending
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic edge_d, edge_q;
        logic prev_d, prev_q;

        always_comb begin
            prev_d = irq_in[i];
            edge_d = edge_q;
            if (irq_in[i] && !prev_q && !lvl_sel[i]) begin
                edge_d = 1'b1;
            end
            if (clr_all || clr_one[i]) begin
                edge_d = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                edge_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                edge_q <= edge_d;
                prev_q <= prev_d;
            end
        end

        assign pending[i] = lvl_sel[i] ? irq_in[i] : edge_q;
    end

endmodule

// File: rtl/pic_prio_pick.sv
`timescale 1ns/1ps
module pic_prio_pick #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned IDX_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Lowest set bit wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pic_vector_gen.sv
`timescale 1ns/1ps
module pic_vector_gen
    import pic_vec_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_port,
    input  logic [VEC_W-1:0]   wr_data,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] lvl_sel,
    input  logic               ack,
    output logic               int_req,
    output logic               vec_oe,
    output logic [VEC_W-1:0]   vec_out,
    output logic               armed
);

    localparam int unsigned CODE_W = $clog2(N_LINES);
    localparam int unsigned BASE_W = VEC_W - CODE_W;

    typedef struct packed {
        logic               ack_q;
        ack_phase_e         phase;
        logic [CODE_W-1:0]  code;
        logic [N_LINES-1:0] isr;
        logic               oe;
        logic [VEC_W-1:0]   vec;
    } ctl_t;

    ctl_t q, d;

    logic               init_start;
    logic               eoi_cmd;
    logic [BASE_W-1:0]  base;
    logic [N_LINES-1:0] pending;
    logic [N_LINES-1:0] clr_one;
    logic               req_any;
    logic [CODE_W-1:0]  req_idx;
    logic               isr_any;
    logic [CODE_W-1:0]  isr_idx;
    logic               eligible;
    logic               ack_rise;

    pic_init_seq #(
        .VEC_W  (VEC_W),
        .CODE_W (CODE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_port    (wr_port),
        .wr_data    (wr_data),
        .init_start (init_start),
        .eoi_cmd    (eoi_cmd),
        .armed      (armed),
        .base       (base)
    );

    pic_req_latch #(
        .N_LINES (N_LINES)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .lvl_sel (lvl_sel),
        .clr_all (init_start),
        .clr_one (clr_one),
        .pending (pending)
    );

    pic_prio_pick #(
        .N_LINES (N_LINES),
        .IDX_W   (CODE_W)
    ) u_pick_req (
        .vec (pending),
        .any (req_any),
        .idx (req_idx)
    );

    pic_prio_pick #(
        .N_LINES (N_LINES),
        .IDX_W   (CODE_W)
    ) u_pick_isr (
        .vec (q.isr),
        .any (isr_any),
        .idx (isr_idx)
    );

    assign eligible = req_any && (!isr_any || (req_idx < isr_idx));
    assign ack_rise = ack && !q.ack_q;
    assign int_req  = armed && eligible;

    always_comb begin
        d       = q;
        clr_one = '0;
        d.ack_q = ack;
        if (init_start) begin
            d.phase = ACK_IDLE;
            d.isr   = '0;
            d.oe    = 1'b0;
            d.vec   = '0;
        end else begin
            if (eoi_cmd && isr_any) begin
                d.isr[isr_idx] = 1'b0;
            end
            unique case (q.phase)
                ACK_IDLE: begin
                    if (armed && ack_rise) begin
                        d.phase = ACK_WAIT2;
                        if (eligible) begin
                            d.code           = req_idx;
                            d.isr[req_idx]   = 1'b1;
                            clr_one[req_idx] = 1'b1;
                        end else begin
                            d.code = '1;
                        end
                    end
                end
                ACK_WAIT2: begin
                    if (ack_rise) begin
                        d.phase = ACK_DRIVE;
                        d.oe    = 1'b1;
                        d.vec   = {base, q.code};
                    end
                end
                ACK_DRIVE: begin
                    if (!ack) begin
                        d.phase = ACK_IDLE;
                        d.oe    = 1'b0;
                        d.vec   = '0;
                    end
                end
                default: d.phase = ACK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ack_q <= 1'b0;
            q.phase <= ACK_IDLE;
            q.code  <= '0;
            q.isr   <= '0;
            q.oe    <= 1'b0;
            q.vec   <= '0;
        end else begin
            q <= d;
        end
    end

    assign vec_oe  = q.oe;
    assign vec_out = q.vec;

endmodule

// File: rtl/pic_vector_gen_chk.sv
`timescale 1ns/1ps
module pic_vector_gen_chk #(
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_port,
    input logic [VEC_W-1:0] wr_data,
    input logic             ack,
    input logic             int_req,
    input logic             vec_oe,
    input logic [VEC_W-1:0] vec_out,
    input logic             armed
);

    // R1: a start byte always leaves the block unarmed next cycle
    p_start_disarms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_port && wr_data[4]) |=> !armed);

    // R6: no request toward the processor before arming completes
    p_req_needs_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> armed);

    // R8: bus enable only ever comes up in an armed block
    p_oe_needs_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> armed);

    // R8: disabled bus reads zero
    p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_out == '0));

    // R8: enable rises only after an acknowledge level was seen
    p_oe_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> $past(ack));

    // R8: vector stays steady while the bus is enabled
    p_vec_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_out));

endmodule

bind pic_vector_gen pic_vector_gen_chk #(.VEC_W(VEC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_port (wr_port),
    .wr_data (wr_data),
    .ack     (ack),
    .int_req (int_req),
    .vec_oe  (vec_oe),
    .vec_out (vec_out),
    .armed   (armed)
);

// File: tb/pic_vector_gen_bench.sv
`timescale 1ns/1ps
module pic_vector_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_port = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] irq_in = 8'h00;
    logic [7:0] lvl_sel = 8'h00;
    logic       ack = 1'b0;
    logic       int_req;
    logic       vec_oe;
    logic [7:0] vec_out;
    logic       armed;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pic_vector_gen u_pic_vector_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_port (wr_port),
        .wr_data (wr_data),
        .irq_in  (irq_in),
        .lvl_sel (lvl_sel),
        .ack     (ack),
        .int_req (int_req),
        .vec_oe  (vec_oe),
        .vec_out (vec_out),
        .armed   (armed)
    );

    // ---------------- behavioural reference ----------------
    int         m_stage;     // 0 idle, 1..3 words still due, 4 ready
    int         m_base;
    bit [7:0]   m_isr, m_edge, m_prev;
    bit         m_ack_prev;
    int         m_phase;     // 0 idle, 1 waiting second pulse, 2 driving
    int         m_code;
    bit         m_oe;
    int         m_vec;

    function automatic int lowest(input bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic int pick_eligible();
        bit [7:0] pend;
        int r, s;
        pend = (m_edge & ~lvl_sel) | (irq_in & lvl_sel);
        r = lowest(pend);
        s = lowest(m_isr);
        if (r < 8 && r < s) return r;
        return 8;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage = 0; m_base = 0; m_isr = 0; m_edge = 0; m_prev = 0;
            m_ack_prev = 0; m_phase = 0; m_code = 0; m_oe = 0; m_vec = 0;
        end else begin
            int win;
            bit [7:0] rises, clr;
            bit start, eoi, rise;
            bit [7:0] n_isr;
            start = wr_en && !wr_port && wr_data[4];
            eoi   = wr_en && !wr_port && !wr_data[4] && wr_data[5] && m_stage == 4;
            rise  = ack && !m_ack_prev;
            win   = pick_eligible();
            rises = irq_in & ~m_prev & ~lvl_sel;
            clr   = 0;
            n_isr = m_isr;
            if (start) begin
                n_isr = 0; m_phase = 0; m_oe = 0; m_vec = 0; clr = 8'hFF;
            end else begin
                if (eoi && lowest(m_isr) < 8) n_isr[lowest(m_isr)] = 0;
                if (m_phase == 0) begin
                    if (m_stage == 4 && rise) begin
                        m_phase = 1;
                        if (win < 8) begin
                            m_code = win; n_isr[win] = 1; clr[win] = 1;
                        end else m_code = 7;
                    end
                end else if (m_phase == 1) begin
                    if (rise) begin
                        m_phase = 2; m_oe = 1; m_vec = m_base * 8 + m_code;
                    end
                end else begin
                    if (!ack) begin
                        m_phase = 0; m_oe = 0; m_vec = 0;
                    end
                end
            end
            m_isr  = n_isr;
            m_edge = (m_edge | rises) & ~clr;
            m_prev = irq_in;
            m_ack_prev = ack;
            if (start) m_stage = 1;
            else if (wr_en && wr_port && m_stage >= 1 && m_stage <= 3) begin
                if (m_stage == 1) m_base = wr_data[7:3];
                m_stage = m_stage + 1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R1 armed", armed, m_stage == 4);
            check("R6 int_req", int_req, (m_stage == 4) && (pick_eligible() < 8));
            check("R8 vec_oe", vec_oe, m_oe);
            check("R3 vec_out", vec_out, m_vec);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit port, input bit [7:0] data);
        @(posedge clk); #1;
        wr_en = 1; wr_port = port; wr_data = data;
        @(posedge clk); #1;
        wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic init_seq(input bit [7:0] b2);
        wr(0, 8'h11);
        wr(1, b2);
        wr(1, 8'h04);
        wr(1, 8'h01);
    endtask

    // two acknowledge pulses; returns vector seen while enabled
    task automatic ack_cycle(output int vec_seen);
        @(posedge clk); #1; ack = 1;
        tick(2); ack = 0;
        tick(2); ack = 1;
        tick(1);
        @(negedge clk); vec_seen = vec_out;
        tick(1); ack = 0;
        tick(2);
    endtask

    int v;

    initial begin
        tick(3);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset armed", armed, 0);
        check("R8 reset oe", vec_oe, 0);
        check("R6 reset int_req", int_req, 0);

        // acknowledge before arming is ignored
        irq_in = 8'h08; tick(2);
        check("R1 unarmed int_req", int_req, 0);
        ack_cycle(v);
        check("R1 unarmed ack", v, 0);
        irq_in = 8'h00;

        // initialization: armed only after the last word
        wr(0, 8'h1B);
        wr(1, 8'h08);
        wr(1, 8'h04);
        @(negedge clk);
        check("R1 armed before last word", armed, 0);
        wr(1, 8'h01);
        @(negedge clk);
        check("R1 armed after last word", armed, 1);

        // single edge line 3
        tick(1); irq_in = 8'h08; tick(2);
        check("R5 edge pending", int_req, 1);
        irq_in = 8'h00; tick(1);
        check("R5 edge latched after drop", int_req, 1);
        ack_cycle(v);
        check("R3 vector line3", v, 8'h0B);
        check("R5 latch cleared", int_req, 0);
        wr(0, 8'h20);

        // edge line 2 against level line 5
        lvl_sel = 8'h20;
        @(posedge clk); #1; irq_in = 8'h24; tick(2);
        ack_cycle(v);
        check("R4 line2 beats line5", v, 8'h0A);
        @(negedge clk);
        check("R4 line5 blocked by isr2", int_req, 0);
        irq_in = 8'h22; tick(2);
        check("R4 line1 nests over isr2", int_req, 1);
        ack_cycle(v);
        check("R7 nested vector", v, 8'h09);
        wr(0, 8'h20);
        @(negedge clk);
        check("R9 first eoi frees isr1 only", int_req, 0);
        wr(0, 8'h20);
        @(negedge clk);
        check("R9 second eoi frees isr2", int_req, 1);
        ack_cycle(v);
        check("R5 level line5 vector", v, 8'h0D);
        irq_in = 8'h00; wr(0, 8'h20); lvl_sel = 8'h00;

        // nothing pending
        tick(2);
        ack_cycle(v);
        check("R7 spurious code", v, 8'h0F);

        // latch an edge, then reinitialize with a mid-sequence restart
        irq_in = 8'h10; tick(2); irq_in = 8'h00;
        wr(0, 8'h10);
        wr(1, 8'h75);
        wr(0, 8'h10);
        @(negedge clk);
        check("R10 restart unarms", armed, 0);
        init_seq(8'h75);
        @(negedge clk);
        check("R10 stale edge cleared", int_req, 0);
        irq_in = 8'h01; tick(2);
        ack_cycle(v);
        check("R2 slave base low bits ignored", v, 8'h70);
        irq_in = 8'h00;
        tick(3);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule